// File: doc/BRIEF.md
# L1 Cache Configuration Tuning Controller

This block runs a greedy search for a low-cost level-one cache configuration during one program phase. It presents one trial configuration at a time, in three codes (total capacity, number of ways, line length). It then waits for an externally measured cost word, such as an energy-delay product, for that trial. It records the cheapest configuration seen. When the search ends, it puts that configuration on its outputs and raises a one-cycle done flag.

A search begins on a start request from the phase logic. The parameters are tuned in a fixed sequence: capacity first, then ways, then line length. Each one moves by a factor of two per trial. A parameter is dropped as soon as a trial costs more than the one it is compared against, or when the next step would leave the legal range. The number of trials in one search has a hard limit, and a new search begins from the result of the previous one.

Code map used on every configuration port (code 3 is never driven):

- capacity: 0 = 2 KB, 1 = 4 KB, 2 = 8 KB
- ways: 0 = direct-mapped, 1 = 2-way, 2 = 4-way
- line length: 0 = 16 B, 1 = 32 B, 2 = 64 B

Top module: `l1_cfg_tuner`

## Requirements
- R1: After reset, done_o is 0 and the configuration outputs hold the full configuration: size_o=2, way_o=2, line_o=2.
- R2: Parameters are tuned in the order capacity, ways, line length. When the block moves to the next parameter, it starts from the cheapest configuration recorded so far and steps only that parameter.
- R3: When tuning of a parameter begins, it steps down by one code (halving) if its code is nonzero, and up by one code (doubling) if its code is 0. Each later step for that parameter keeps the same direction, one code per trial.
- R4: A parameter's tuning ends when the trial cost is strictly greater than the reference cost. The reference is the previous trial's cost, or the cheapest cost so far for the first trial of a newly started parameter. An equal cost lets the search continue.
- R5: If the next step of the current parameter would leave the code range 0..2, the block moves to the next parameter and spends no trial on the illegal value.
- R6: The recorded best is replaced only by a strictly lower unsigned 32-bit cost. On a tie, the earlier configuration is kept.
- R7: A search ends after at most MAX_EXEC cost reports (default 3), even if parameters remain untried.
- R8: At the end of a search, done_o is 1 for exactly one cycle. In that same cycle the outputs show the cheapest configuration, and they hold it until the next search begins.
- R9: A new search presents, as its first trial, the configuration that the previous search ended with. After reset this is the full configuration.
- R10: start_i is ignored while a search is running. cost_vld_i is ignored while no search is running.
- R11: No configuration output ever carries code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to tune for a new phase |
| cost_vld_i | input | 1 | Cost word for the present trial is valid |
| cost_i | input | 32 | Measured unsigned cost of the present trial |
| size_o | output | 2 | Capacity code of the trial or final configuration |
| way_o | output | 2 | Associativity code of the trial or final configuration |
| line_o | output | 2 | Line-length code of the trial or final configuration |
| done_o | output | 1 | One-cycle pulse when the final configuration is valid |

## Verification
The bench feeds a tie on the same trial where the ways parameter hits its lower limit. A design that replaced the best on a tie, or that spent a trial on an illegal code, would end on a different configuration. It also starts a parameter from the lowest code, so that a design stepping only downward would show code 3 or repeat a value. It sends a start request and a stray cost strobe at the wrong moments, so a design that restarted or advanced would change its outputs. A reduced-limit instance must stop after exactly its trial budget, and a design with an off-by-one count would present one more trial or stop one early. Costs near the top of the 32-bit range are compared so that a signed compare would pick the wrong configuration.

// File: rtl/cfg_tuner_pkg.sv
package cfg_tuner_pkg;
  localparam int NFIELD = 3;          // 0 capacity, 1 ways, 2 line length
  localparam int FW     = 2;
  localparam logic [FW-1:0] CODE_MAX = 2'd2;
  typedef logic [NFIELD-1:0][FW-1:0] cfg_t;
  localparam cfg_t CFG_FULL = {2'd2, 2'd2, 2'd2};
  typedef enum logic {ST_IDLE, ST_RUN} st_t;
endpackage

// File: rtl/cfg_tuner_step.sv
module cfg_tuner_step
  import cfg_tuner_pkg::*;
(
  input  logic [FW-1:0] cur_code,
  input  logic          down,
  input  logic [FW-1:0] seed_code,
  output logic [FW-1:0] cont_code,
  output logic          cont_lim,
  output logic [FW-1:0] seed_next,
  output logic          seed_down
);
  always_comb begin
    cont_lim  = down ? (cur_code == '0) : (cur_code == CODE_MAX);
    cont_code = cont_lim ? cur_code : (down ? cur_code - 1'b1 : cur_code + 1'b1);
    seed_down = (seed_code != '0);
    seed_next = seed_down ? seed_code - 1'b1 : seed_code + 1'b1;
  end
endmodule

// File: rtl/cfg_tuner_best.sv
module cfg_tuner_best
  import cfg_tuner_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic [CW-1:0] cost,
  input  cfg_t          cand,
  output cfg_t          nb_cfg,
  output logic [CW-1:0] nb_cost
);
  cfg_t          best_q;
  logic [CW-1:0] cost_q;
  logic          empty_q;
  logic          take;

  always_comb begin
    take    = upd && (empty_q || cost < cost_q);
    nb_cfg  = take ? cand : best_q;
    nb_cost = take ? cost : cost_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_q  <= CFG_FULL;
      cost_q  <= '0;
      empty_q <= 1'b1;
    end else if (clear) begin
      empty_q <= 1'b1;
    end else if (upd) begin
      best_q  <= nb_cfg;
      cost_q  <= nb_cost;
      empty_q <= 1'b0;
    end
  end

  AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!empty_q && !clear) |=> (cost_q <= $past(cost_q))); // R6
endmodule

// File: rtl/l1_cfg_tuner.sv
module l1_cfg_tuner
  import cfg_tuner_pkg::*;
#(
  parameter int CW       = 32,
  parameter int MAX_EXEC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          cost_vld_i,
  input  logic [CW-1:0] cost_i,
  output logic [1:0]    size_o,
  output logic [1:0]    way_o,
  output logic [1:0]    line_o,
  output logic          done_o
);
  localparam int TW = $clog2(MAX_EXEC + 1);
  localparam logic [TW-1:0] TRIAL_LIMIT = TW'(MAX_EXEC);

  st_t           st_q;
  cfg_t          cur_q;
  logic [1:0]    par_q;
  logic          down_q;
  logic [CW-1:0] ref_q;
  logic          first_q;
  logic [TW-1:0] trials_q;

  cfg_t          nb_cfg;
  logic [CW-1:0] nb_cost;
  logic [NFIELD-1:0][FW-1:0] cont_code, seed_next;
  logic [NFIELD-1:0]         cont_lim, seed_down;

  logic          upd, rose, move_on, finish;
  logic [TW-1:0] trials_n;
  logic [1:0]    par_nx;

  assign upd = (st_q == ST_RUN) && cost_vld_i;

  cfg_tuner_best #(.CW(CW)) u_best (
    .clk(clk), .rst(rst),
    .clear((st_q == ST_IDLE) && start_i),
    .upd(upd), .cost(cost_i), .cand(cur_q),
    .nb_cfg(nb_cfg), .nb_cost(nb_cost)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_step
    cfg_tuner_step u_step (
      .cur_code(cur_q[g]), .down(down_q), .seed_code(nb_cfg[g]),
      .cont_code(cont_code[g]), .cont_lim(cont_lim[g]),
      .seed_next(seed_next[g]), .seed_down(seed_down[g])
    );
  end

  always_comb begin
    trials_n = trials_q + 1'b1;
    rose     = !first_q && (cost_i > ref_q);
    move_on  = rose || cont_lim[par_q];
    finish   = (trials_n >= TRIAL_LIMIT) || (move_on && par_q == 2'd2);
    par_nx   = par_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cur_q    <= CFG_FULL;
      par_q    <= '0;
      down_q   <= 1'b1;
      ref_q    <= '0;
      first_q  <= 1'b1;
      trials_q <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q     <= ST_RUN;
          par_q    <= '0;
          down_q   <= (cur_q[0] != '0);
          first_q  <= 1'b1;
          trials_q <= '0;
        end
      end else if (cost_vld_i) begin
        trials_q <= trials_n;
        first_q  <= 1'b0;
        if (finish) begin
          cur_q  <= nb_cfg;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end else if (!move_on) begin
          cur_q[par_q] <= cont_code[par_q];
          ref_q        <= cost_i;
        end else begin
          par_q         <= par_nx;
          cur_q         <= nb_cfg;
          cur_q[par_nx] <= seed_next[par_nx];
          down_q        <= seed_down[par_nx];
          ref_q         <= nb_cost;
        end
      end
    end
  end

  assign size_o = cur_q[0];
  assign way_o  = cur_q[1];
  assign line_o = cur_q[2];

  AST_CODES_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (size_o != 2'd3) && (way_o != 2'd3) && (line_o != 2'd3)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_TRIAL_CAP: assert property (@(posedge clk) disable iff (rst)
    trials_q <= TRIAL_LIMIT); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !start_i) |=> $stable(cur_q)); // R10
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !cost_vld_i) |=> ($stable(cur_q) && st_q == ST_RUN)); // R10
  AST_PARAM_RANGE: assert property (@(posedge clk) disable iff (rst)
    par_q <= 2'd2); // R2
endmodule

// File: tb/l1_cfg_tuner_test.sv
module l1_cfg_tuner_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, cost_vld_i = 1'b0;
  logic [31:0] cost_i = '0;
  logic [1:0] size_o, way_o, line_o;
  logic done_o;
  logic start_c = 1'b0, vld_c = 1'b0;
  logic [31:0] cost_c = '0;
  logic [1:0] size_c, way_c, line_c;
  logic done_c;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  l1_cfg_tuner #(.MAX_EXEC(7)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .cost_vld_i(cost_vld_i),
    .cost_i(cost_i), .size_o(size_o), .way_o(way_o), .line_o(line_o), .done_o(done_o));

  l1_cfg_tuner uut_cap (
    .clk(clk), .rst(rst), .start_i(start_c), .cost_vld_i(vld_c),
    .cost_i(cost_c), .size_o(size_c), .way_o(way_c), .line_o(line_c), .done_o(done_c));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input logic [1:0] s, input logic [1:0] w, input logic [1:0] l, input string tag);
    check({2'b0, size_o, way_o, line_o}, {2'b0, s, w, l}, tag);
  endtask

  task automatic begin_search();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic trial(input logic [1:0] s, input logic [1:0] w, input logic [1:0] l,
                       input logic [31:0] c, input string tag);
    chk_cfg(s, w, l, tag);
    check({7'b0, done_o}, 8'h0, {tag, " done low"});
    cost_i = c; cost_vld_i = 1'b1;
    @(negedge clk);
    cost_vld_i = 1'b0;
  endtask

  task automatic expect_done(input logic [1:0] s, input logic [1:0] w, input logic [1:0] l, input string tag);
    check({7'b0, done_o}, 8'h1, {tag, " done pulse R8"});
    chk_cfg(s, w, l, {tag, " final R8"});
    @(negedge clk);
    check({7'b0, done_o}, 8'h0, {tag, " done one cycle R8"});
    chk_cfg(s, w, l, {tag, " held R8"});
  endtask

  task automatic t_reset();
    check({7'b0, done_o}, 8'h0, "R1 done after reset");
    chk_cfg(2, 2, 2, "R1 reset config");
    // stray cost while idle must not move anything
    cost_i = 32'd5; cost_vld_i = 1'b1; @(negedge clk); cost_vld_i = 1'b0;
    chk_cfg(2, 2, 2, "R10 idle cost ignored");
    check({7'b0, done_o}, 8'h0, "R10 idle cost no done");
  endtask

  task automatic t_full_walk();
    begin_search();
    trial(2, 2, 2, 100, "R9 first trial from full");
    trial(1, 2, 2, 80,  "R3 size halves");
    trial(0, 2, 2, 90,  "R3 size again");
    trial(1, 1, 2, 70,  "R2 ways from best R4");
    trial(1, 0, 2, 70,  "R3 ways down");
    trial(1, 1, 1, 60,  "R5 limit skip R6 tie keeps earlier");
    trial(1, 1, 0, 65,  "R2 line tuned last");
    expect_done(1, 1, 1, "R4 line rise ends");
  endtask

  task automatic t_second_walk();
    begin_search();
    trial(1, 1, 1, 50, "R9 starts from last final");
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk_cfg(0, 1, 1, "R10 start ignored while busy");
    trial(0, 1, 1, 60, "R3 size down");
    trial(1, 0, 1, 40, "R4 rise moves to ways");
    trial(1, 0, 0, 45, "R5 ways limit moves to line");
    expect_done(1, 0, 1, "R4 second walk");
  endtask

  task automatic t_upward();
    begin_search();
    trial(1, 0, 1, 32'hFFFF_FFF0, "R9 third start");
    trial(0, 0, 1, 32'hFFFF_FFF8, "R6 unsigned rise");
    trial(1, 1, 1, 32'hFFFF_FFF4, "R3 ways steps up from 0");
    trial(1, 0, 0, 32'h7FFF_FFFF, "R4 ways rise then line");
    expect_done(1, 0, 0, "R5 line limit ends search");
  endtask

  task automatic t_cap();
    check({2'b0, size_c, way_c, line_c}, {2'b0, 2'd2, 2'd2, 2'd2}, "R1 cap reset");
    start_c = 1'b1; @(negedge clk); start_c = 1'b0;
    cost_c = 100; vld_c = 1'b1; @(negedge clk); vld_c = 1'b0;
    cost_c = 90;  vld_c = 1'b1; @(negedge clk); vld_c = 1'b0;
    check({2'b0, size_c, way_c, line_c}, {2'b0, 2'd0, 2'd2, 2'd2}, "R7 third trial");
    check({7'b0, done_c}, 8'h0, "R7 no early done");
    cost_c = 80;  vld_c = 1'b1; @(negedge clk); vld_c = 1'b0;
    check({7'b0, done_c}, 8'h1, "R7 done after three trials");
    check({2'b0, size_c, way_c, line_c}, {2'b0, 2'd0, 2'd2, 2'd2}, "R7 best at cap");
    @(negedge clk);
    check({7'b0, done_c}, 8'h0, "R8 cap done one cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_second_walk();
    t_upward();
    t_cap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule